// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the register front end through which a host processor hands commands to an embedded power-management controller. The host sees a small set of 32-bit registers: a command word, a status word, two pointer words, a write buffer of four words and a read buffer of four words. Writing the command word is the doorbell. The block latches the command, marks itself busy and sends a one-cycle pulse to the controller. The controller then reads the command fields, the pointers and the write buffer, puts any reply into the read buffer and signals completion with an error flag and an 8-bit error code.

On completion the busy flag drops and the error result is latched into the status word. If the command asked for it, an interrupt flag is set and drives the host interrupt line. The host clears that flag by writing 1 to it. A host that did not ask for an interrupt polls the busy bit instead. A second command that arrives while one is still outstanding is dropped, and a sticky overrun flag records the drop.

The host bus has a single cycle for each access. Read data is combinational from the selected register in the same cycle. A write takes effect at the clock edge of the cycle in which it is presented. Only word-aligned offsets decode.

Top module: `mbox_host_ctl`

## Requirements
- R1: After reset every register and buffer word reads 0, the status word is 0, host_irq is low and ctl_doorbell is low.
- R2: An aligned write to offset 0x00 while busy is clear stores the word. From the next cycle busy (status bit 0) reads 1, the error flag and error code read 0, and ctl_doorbell is high for exactly that one cycle.
- R3: The controller sees the stored command split into fields: code = bits 7:0, interrupt request = bit 8, subcommand = bits 15:12, payload length = bits 20:16. ctl_wr_words is the length rounded up to whole 4-byte words, saturated at 4 (so 0→0, 1→1, 5→2, 16→4, 17→4).
- R4: The destination pointer (offset 0x08) and the source pointer (offset 0x0C) are host read/write registers. They drive ctl_dptr and ctl_sptr unchanged.
- R5: The write buffer at offsets 0x80, 0x84, 0x88 and 0x8C (word index 0 to 3) can be written and read back by the host. The controller reads it by index on ctl_wbuf_idx / ctl_wbuf_data.
- R6: The read buffer at offsets 0x90 to 0x9C (index 0 to 3) is filled by the controller through ctl_rbuf_we, ctl_rbuf_idx and ctl_rbuf_data, and the host reads it. Host writes to it change nothing.
- R7: ctl_done while busy clears busy on the next cycle. It also latches status bit 1 = ctl_err and status bits 23:16 = ctl_err_code when ctl_err is 1, and 0 when ctl_err is 0. ctl_done while idle changes nothing.
- R8: On completion, status bit 2 and host_irq are set only when command bit 8 was 1. A status write with bit 2 = 1 clears them, and a status write with bit 2 = 0 leaves them as they are. A set and a clear in the same cycle leave the flag set.
- R9: A command write while busy is ignored: the command register keeps its value and no doorbell pulse is sent. Instead status bit 3 (overrun) is set and stays set until a status write with bit 3 = 1.
- R10: Reads of unused or unaligned offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, same cycle |
| host_irq | output | 1 | Completion interrupt to host |
| ctl_doorbell | output | 1 | One-cycle new-command pulse |
| ctl_cmd_code | output | 8 | Command code field |
| ctl_subcmd | output | 4 | Subcommand field |
| ctl_len | output | 5 | Payload length in bytes |
| ctl_wr_words | output | 3 | Write-buffer words in use |
| ctl_irq_req | output | 1 | Command asked for an interrupt |
| ctl_dptr | output | 32 | Destination pointer |
| ctl_sptr | output | 32 | Source pointer |
| ctl_wbuf_idx | input | 2 | Write-buffer word index |
| ctl_wbuf_data | output | 32 | Write-buffer word at that index |
| ctl_rbuf_we | input | 1 | Read-buffer write strobe |
| ctl_rbuf_idx | input | 2 | Read-buffer word index |
| ctl_rbuf_data | input | 32 | Read-buffer write data |
| ctl_done | input | 1 | Command complete |
| ctl_err | input | 1 | Completion reports an error |
| ctl_err_code | input | 8 | Error code on completion |

## Verification
The main command path is driven with random command words that vary the code, the subcommand, the interrupt-request bit and the length, including lengths above the 16-byte limit. Mixed into that are random pointer and buffer contents and random error outcomes. Random lengths separate the rounding rule from the saturation rule. Varying the interrupt-request bit separates polled completion from interrupting completion, and random error codes show whether the code is latched only when the error flag is set. Random second commands during busy periods check the overrun path. Directed cases then cover the other corners: completion while idle, a status write with 0 in the clear bit, host writes into the read buffer, and unused and unaligned offsets.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned ERR_W = 8;

    // Register map (byte offsets)
    localparam int unsigned OFS_CMD  = 'h00;
    localparam int unsigned OFS_STS  = 'h04;
    localparam int unsigned OFS_DPTR = 'h08;
    localparam int unsigned OFS_SPTR = 'h0C;
    localparam int unsigned OFS_WBUF = 'h80;
    localparam int unsigned OFS_RBUF = 'h90;

    // Status word bit positions
    localparam int unsigned STS_BUSY  = 0;
    localparam int unsigned STS_ERR   = 1;
    localparam int unsigned STS_IRQ   = 2;
    localparam int unsigned STS_OVR   = 3;
    localparam int unsigned STS_CODE  = 16;

    // Command word field positions
    localparam int unsigned CMD_IRQ_BIT = 8;
    localparam int unsigned CMD_SUB_LSB = 12;
    localparam int unsigned CMD_LEN_LSB = 16;

    typedef struct packed {
        logic [DW-1:0]    cmd;
        logic [DW-1:0]    dptr;
        logic [DW-1:0]    sptr;
        logic             busy;
        logic             err;
        logic [ERR_W-1:0] code;
        logic             irq;
        logic             ovr;
        logic             bell;
    } mbox_state_t;

endpackage

// File: rtl/mbox_wordbuf.sv
module mbox_wordbuf #(
    parameter int unsigned WORDS = 4,
    parameter int unsigned DW    = 32,
    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [DW-1:0]    rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [DW-1:0]    rd_b_data
);

    logic [DW-1:0] mem_d [WORDS];
    logic [DW-1:0] mem_q [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en && (int'(wr_idx) < WORDS)) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    assign rd_a_data = (int'(rd_a_idx) < WORDS) ? mem_q[rd_a_idx] : '0;
    assign rd_b_data = (int'(rd_b_idx) < WORDS) ? mem_q[rd_b_idx] : '0;

endmodule

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned WORDS  = 4,
    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int unsigned WA_W  = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_cmd,
    output logic              hit_sts,
    output logic              hit_dptr,
    output logic              hit_sptr,
    output logic              hit_wbuf,
    output logic              hit_rbuf,
    output logic [IDX_W-1:0]  wbuf_idx,
    output logic [IDX_W-1:0]  rbuf_idx
);

    localparam logic [WA_W-1:0] WA_CMD  = WA_W'(OFS_CMD / 4);
    localparam logic [WA_W-1:0] WA_STS  = WA_W'(OFS_STS / 4);
    localparam logic [WA_W-1:0] WA_DPTR = WA_W'(OFS_DPTR / 4);
    localparam logic [WA_W-1:0] WA_SPTR = WA_W'(OFS_SPTR / 4);
    localparam logic [WA_W-1:0] WB_LO   = WA_W'(OFS_WBUF / 4);
    localparam logic [WA_W-1:0] WB_HI   = WA_W'(OFS_WBUF / 4 + WORDS);
    localparam logic [WA_W-1:0] RB_LO   = WA_W'(OFS_RBUF / 4);
    localparam logic [WA_W-1:0] RB_HI   = WA_W'(OFS_RBUF / 4 + WORDS);

    logic            aligned;
    logic [WA_W-1:0] wa;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        wa       = addr[ADDR_W-1:2];
        hit_cmd  = aligned && (wa == WA_CMD);
        hit_sts  = aligned && (wa == WA_STS);
        hit_dptr = aligned && (wa == WA_DPTR);
        hit_sptr = aligned && (wa == WA_SPTR);
        hit_wbuf = aligned && (wa >= WB_LO) && (wa < WB_HI);
        hit_rbuf = aligned && (wa >= RB_LO) && (wa < RB_HI);
        wbuf_idx = IDX_W'(wa - WB_LO);
        rbuf_idx = IDX_W'(wa - RB_LO);
    end

    always_comb begin
        AST_DECODE_EXCLUSIVE: assert ($onehot0({hit_cmd, hit_sts, hit_dptr,
                                                hit_sptr, hit_wbuf, hit_rbuf})); // R10
    end

endmodule

// File: rtl/mbox_host_ctl.sv
module mbox_host_ctl
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BUF_WORDS = 4,
    parameter int unsigned CODE_W    = 8,
    parameter int unsigned SUB_W     = 4,
    parameter int unsigned LEN_W     = 5,
    localparam int unsigned IDX_W  = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
    localparam int unsigned WCNT_W = $clog2(BUF_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              host_irq,
    output logic              ctl_doorbell,
    output logic [CODE_W-1:0] ctl_cmd_code,
    output logic [SUB_W-1:0]  ctl_subcmd,
    output logic [LEN_W-1:0]  ctl_len,
    output logic [WCNT_W-1:0] ctl_wr_words,
    output logic              ctl_irq_req,
    output logic [DW-1:0]     ctl_dptr,
    output logic [DW-1:0]     ctl_sptr,
    input  logic [IDX_W-1:0]  ctl_wbuf_idx,
    output logic [DW-1:0]     ctl_wbuf_data,
    input  logic              ctl_rbuf_we,
    input  logic [IDX_W-1:0]  ctl_rbuf_idx,
    input  logic [DW-1:0]     ctl_rbuf_data,
    input  logic              ctl_done,
    input  logic              ctl_err,
    input  logic [ERR_W-1:0]  ctl_err_code
);

    mbox_state_t st_d, st_q;

    logic             hit_cmd, hit_sts, hit_dptr, hit_sptr, hit_wbuf, hit_rbuf;
    logic [IDX_W-1:0] hbuf_widx, hbuf_ridx;
    logic             wr_acc, rd_acc;
    logic             cmd_wr, sts_wr, wbuf_wr;
    logic [DW-1:0]    wbuf_host_rd, rbuf_host_rd, unused_rbuf_b, sts_word;
    logic [LEN_W:0]   len_up;
    logic [LEN_W:0]   wcnt_raw;

    mbox_decode #(.ADDR_W(ADDR_W), .WORDS(BUF_WORDS)) u_decode (
        .addr     (bus_addr),
        .hit_cmd  (hit_cmd),
        .hit_sts  (hit_sts),
        .hit_dptr (hit_dptr),
        .hit_sptr (hit_sptr),
        .hit_wbuf (hit_wbuf),
        .hit_rbuf (hit_rbuf),
        .wbuf_idx (hbuf_widx),
        .rbuf_idx (hbuf_ridx)
    );

    assign wr_acc  = bus_sel && bus_wr;
    assign rd_acc  = bus_sel && !bus_wr;
    assign cmd_wr  = wr_acc && hit_cmd;
    assign sts_wr  = wr_acc && hit_sts;
    assign wbuf_wr = wr_acc && hit_wbuf;

    // Host-written buffer: host port writes, controller port reads
    mbox_wordbuf #(.WORDS(BUF_WORDS), .DW(DW)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wbuf_wr),
        .wr_idx    (hbuf_widx),
        .wr_data   (bus_wdata),
        .rd_a_idx  (hbuf_widx),
        .rd_a_data (wbuf_host_rd),
        .rd_b_idx  (ctl_wbuf_idx),
        .rd_b_data (ctl_wbuf_data)
    );

    // Controller-written buffer: host only reads
    mbox_wordbuf #(.WORDS(BUF_WORDS), .DW(DW)) u_rbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_rbuf_we),
        .wr_idx    (ctl_rbuf_idx),
        .wr_data   (ctl_rbuf_data),
        .rd_a_idx  (hbuf_ridx),
        .rd_a_data (rbuf_host_rd),
        .rd_b_idx  (ctl_rbuf_idx),
        .rd_b_data (unused_rbuf_b)
    );

    // Next-state computation. Order inside the cycle: clear requests, then
    // completion (so a set wins over a clear), then the command write which
    // is judged against the busy value held at the start of the cycle.
    always_comb begin
        st_d      = st_q;
        st_d.bell = 1'b0;

        if (sts_wr) begin
            if (bus_wdata[STS_IRQ]) st_d.irq = 1'b0;
            if (bus_wdata[STS_OVR]) st_d.ovr = 1'b0;
        end

        if (ctl_done && st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.err  = ctl_err;
            st_d.code = ctl_err ? ctl_err_code : '0;
            if (st_q.cmd[CMD_IRQ_BIT]) st_d.irq = 1'b1;
        end

        if (cmd_wr) begin
            if (st_q.busy) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.cmd  = bus_wdata;
                st_d.busy = 1'b1;
                st_d.err  = 1'b0;
                st_d.code = '0;
                st_d.bell = 1'b1;
            end
        end

        if (wr_acc && hit_dptr) st_d.dptr = bus_wdata;
        if (wr_acc && hit_sptr) st_d.sptr = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Status word assembly and host read mux
    always_comb begin
        sts_word                        = '0;
        sts_word[STS_BUSY]              = st_q.busy;
        sts_word[STS_ERR]               = st_q.err;
        sts_word[STS_IRQ]               = st_q.irq;
        sts_word[STS_OVR]               = st_q.ovr;
        sts_word[STS_CODE +: ERR_W]     = st_q.code;

        bus_rdata = '0;
        if (rd_acc) begin
            if (hit_cmd)  bus_rdata = st_q.cmd;
            if (hit_sts)  bus_rdata = sts_word;
            if (hit_dptr) bus_rdata = st_q.dptr;
            if (hit_sptr) bus_rdata = st_q.sptr;
            if (hit_wbuf) bus_rdata = wbuf_host_rd;
            if (hit_rbuf) bus_rdata = rbuf_host_rd;
        end
    end

    // Controller-side command fields
    always_comb begin
        ctl_cmd_code = st_q.cmd[CODE_W-1:0];
        ctl_subcmd   = st_q.cmd[CMD_SUB_LSB +: SUB_W];
        ctl_len      = st_q.cmd[CMD_LEN_LSB +: LEN_W];
        ctl_irq_req  = st_q.cmd[CMD_IRQ_BIT];
        len_up       = {1'b0, ctl_len} + (LEN_W+1)'(3);
        wcnt_raw     = len_up >> 2;
        ctl_wr_words = (int'(wcnt_raw) > BUF_WORDS) ? WCNT_W'(BUF_WORDS)
                                                    : WCNT_W'(wcnt_raw);
    end

    assign ctl_dptr     = st_q.dptr;
    assign ctl_sptr     = st_q.sptr;
    assign ctl_doorbell = st_q.bell;
    assign host_irq     = st_q.irq;

    // Assertions
    AST_BELL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_doorbell |=> !ctl_doorbell); // R2

    AST_BELL_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_doorbell |-> st_q.busy); // R2

    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && st_q.busy && !cmd_wr) |=> !st_q.busy); // R7

    AST_ERR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && st_q.busy && ctl_err) |=> (st_q.err && st_q.code == $past(ctl_err_code))); // R7

    AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> ctl_irq_req); // R8

    AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && st_q.busy) |=> (!ctl_doorbell && st_q.ovr && $stable(st_q.cmd))); // R9

endmodule

// File: tb/mbox_host_ctl_tb.sv
module mbox_host_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        host_irq, ctl_doorbell, ctl_irq_req;
    logic [7:0]  ctl_cmd_code;
    logic [3:0]  ctl_subcmd;
    logic [4:0]  ctl_len;
    logic [2:0]  ctl_wr_words;
    logic [31:0] ctl_dptr, ctl_sptr, ctl_wbuf_data;
    logic [1:0]  ctl_wbuf_idx = '0, ctl_rbuf_idx = '0;
    logic        ctl_rbuf_we = 1'b0;
    logic [31:0] ctl_rbuf_data = '0;
    logic        ctl_done = 1'b0, ctl_err = 1'b0;
    logic [7:0]  ctl_err_code = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_host_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_irq(host_irq), .ctl_doorbell(ctl_doorbell),
        .ctl_cmd_code(ctl_cmd_code), .ctl_subcmd(ctl_subcmd), .ctl_len(ctl_len),
        .ctl_wr_words(ctl_wr_words), .ctl_irq_req(ctl_irq_req),
        .ctl_dptr(ctl_dptr), .ctl_sptr(ctl_sptr),
        .ctl_wbuf_idx(ctl_wbuf_idx), .ctl_wbuf_data(ctl_wbuf_data),
        .ctl_rbuf_we(ctl_rbuf_we), .ctl_rbuf_idx(ctl_rbuf_idx), .ctl_rbuf_data(ctl_rbuf_data),
        .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_err_code(ctl_err_code)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // Reference model state
    logic [31:0] m_cmd, m_dptr, m_sptr;
    logic        m_busy, m_err, m_irq, m_ovr;
    logic [7:0]  m_code;
    logic [31:0] m_wbuf [4];
    logic [31:0] m_rbuf [4];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_status();
        return {8'h00, m_code, 12'h000, m_ovr, m_irq, m_err, m_busy};
    endfunction

    function automatic logic [2:0] f_words(input logic [4:0] len);
        int w;
        w = (int'(len) + 3) / 4;
        if (w > 4) w = 4;
        return 3'(w);
    endfunction

    function automatic logic [31:0] f_read(input logic [7:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a == 8'h00) return m_cmd;
        if (a == 8'h04) return f_status();
        if (a == 8'h08) return m_dptr;
        if (a == 8'h0C) return m_sptr;
        if (a >= 8'h80 && a < 8'h90) return m_wbuf[(a - 8'h80) >> 2];
        if (a >= 8'h90 && a < 8'hA0) return m_rbuf[(a - 8'h90) >> 2];
        return 32'h0;
    endfunction

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Host write plus model update; returns whether a doorbell is expected
    task automatic hw(input logic [7:0] a, input logic [31:0] d, output logic bell);
        bell = 1'b0;
        bwrite(a, d);
        if (a[1:0] == 2'b00) begin
            if (a == 8'h00) begin
                if (m_busy) m_ovr = 1'b1;
                else begin
                    m_cmd = d; m_busy = 1'b1; m_err = 1'b0; m_code = '0; bell = 1'b1;
                end
            end else if (a == 8'h04) begin
                if (d[2]) m_irq = 1'b0;
                if (d[3]) m_ovr = 1'b0;
            end else if (a == 8'h08) m_dptr = d;
            else if (a == 8'h0C) m_sptr = d;
            else if (a >= 8'h80 && a < 8'h90) m_wbuf[(a - 8'h80) >> 2] = d;
        end
    endtask

    task automatic hread_chk(input string tag, input logic [7:0] a);
        logic [31:0] d;
        bread(a, d);
        chk(tag, d, f_read(a));
    endtask

    task automatic cdone(input logic e, input logic [7:0] c);
        @(negedge clk);
        ctl_done = 1'b1; ctl_err = e; ctl_err_code = c;
        @(posedge clk); #1;
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0;
        if (m_busy) begin
            m_busy = 1'b0; m_err = e; m_code = e ? c : 8'h00;
            if (m_cmd[8]) m_irq = 1'b1;
        end
    endtask

    task automatic cfill(input logic [1:0] i, input logic [31:0] d);
        @(negedge clk);
        ctl_rbuf_we = 1'b1; ctl_rbuf_idx = i; ctl_rbuf_data = d;
        @(posedge clk); #1;
        ctl_rbuf_we = 1'b0;
        m_rbuf[i] = d;
    endtask

    task automatic check_fields(input string tag);
        chk({tag, " code"}, 32'(ctl_cmd_code), 32'(m_cmd[7:0]));
        chk({tag, " sub"},  32'(ctl_subcmd),   32'(m_cmd[15:12]));
        chk({tag, " len"},  32'(ctl_len),      32'(m_cmd[20:16]));
        chk({tag, " irqreq"}, 32'(ctl_irq_req), 32'(m_cmd[8]));
        chk({tag, " words"}, 32'(ctl_wr_words), 32'(f_words(m_cmd[20:16])));
    endtask

    task automatic issue_cmd(input logic [31:0] c);
        logic bell;
        hw(8'h00, c, bell);
        chk("R2 doorbell on accepted cmd", 32'(ctl_doorbell), 32'(bell));
        @(posedge clk); #1;
        chk("R2 doorbell lasts one cycle", 32'(ctl_doorbell), 32'h0);
        hread_chk("R2 status after cmd", 8'h04);
        check_fields("R3");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic bell;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        m_cmd = '0; m_dptr = '0; m_sptr = '0;
        m_busy = 0; m_err = 0; m_irq = 0; m_ovr = 0; m_code = '0;
        for (int i = 0; i < 4; i++) begin m_wbuf[i] = '0; m_rbuf[i] = '0; end

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk("R1 host_irq reset", 32'(host_irq), 32'h0);
        chk("R1 doorbell reset", 32'(ctl_doorbell), 32'h0);
        foreach (m_wbuf[i]) hread_chk("R1 wbuf reset", 8'(8'h80 + 4*i));
        foreach (m_rbuf[i]) hread_chk("R1 rbuf reset", 8'(8'h90 + 4*i));
        hread_chk("R1 status reset", 8'h04);
        hread_chk("R1 cmd reset", 8'h00);

        // R10: unused and unaligned offsets
        hw(8'h10, 32'hDEADBEEF, bell);
        hw(8'h01, 32'hFFFFFFFF, bell);
        hread_chk("R10 unused 0x10", 8'h10);
        hread_chk("R10 unused 0x40", 8'h40);
        hread_chk("R10 unused 0xA0", 8'hA0);
        hread_chk("R10 unaligned 0x01", 8'h01);
        hread_chk("R10 unaligned 0x82", 8'h82);
        hread_chk("R10 cmd untouched", 8'h00);
        chk("R10 no doorbell on unaligned cmd", 32'(ctl_doorbell), 32'h0);

        // R7: completion while idle is ignored
        cdone(1'b1, 8'h5A);
        hread_chk("R7 idle done ignored", 8'h04);

        // R6: host writes to read buffer ignored
        cfill(2'd1, 32'h12345678);
        hw(8'h94, 32'hCAFEF00D, bell);
        hread_chk("R6 rbuf host write ignored", 8'h94);

        // R3: directed length corners
        begin
            logic [4:0] lens [6] = '{5'd0, 5'd1, 5'd4, 5'd5, 5'd16, 5'd17};
            foreach (lens[k]) begin
                issue_cmd({11'h0, lens[k], 4'h3, 4'h0, 8'h21});
                cdone(1'b0, 8'h00);
            end
        end

        // R8: status write with bit 2 = 0 leaves irq; then W1C
        issue_cmd(32'h0000_0142);
        cdone(1'b1, 8'h07);
        chk("R8 irq set on request", 32'(host_irq), 32'h1);
        hw(8'h04, 32'h0000_0000, bell);
        chk("R8 zero write keeps irq", 32'(host_irq), 32'h1);
        hread_chk("R7 error code latched", 8'h04);
        hw(8'h04, 32'h0000_0004, bell);
        chk("R8 W1C clears irq", 32'(host_irq), 32'h0);
        hread_chk("R8 status after clear", 8'h04);

        // Random main flow
        for (int it = 0; it < 60; it++) begin
            logic [31:0] c;
            logic [4:0]  len;
            hw(8'h08, $urandom, bell);
            hw(8'h0C, $urandom, bell);
            chk("R4 dptr passthrough", ctl_dptr, m_dptr);
            chk("R4 sptr passthrough", ctl_sptr, m_sptr);
            for (int w = 0; w < 4; w++) hw(8'(8'h80 + 4*w), $urandom, bell);
            len = 5'($urandom % 21);
            c = $urandom;
            c[31:21] = '0;
            c[20:16] = len;
            issue_cmd(c);
            hread_chk("R2 cmd readback", 8'h00);
            for (int w = 0; w < 4; w++) begin
                @(negedge clk);
                ctl_wbuf_idx = 2'(w);
                #1 chk("R5 controller reads wbuf", ctl_wbuf_data, m_wbuf[w]);
            end
            hread_chk("R5 host reads wbuf", 8'h88);
            if ($urandom % 3 == 0) begin
                hw(8'h00, $urandom, bell);
                chk("R9 no doorbell when busy", 32'(ctl_doorbell), 32'h0);
                hread_chk("R9 overrun flag", 8'h04);
                hread_chk("R9 cmd kept", 8'h00);
                check_fields("R9");
            end
            for (int w = 0; w < 4; w++) cfill(2'(w), $urandom);
            for (int w = 0; w < 4; w++) hread_chk("R6 host reads rbuf", 8'(8'h90 + 4*w));
            cdone(1'($urandom), 8'($urandom));
            hread_chk("R7 status after completion", 8'h04);
            chk("R8 host_irq follows request", 32'(host_irq), 32'(m_irq));
            if (m_irq || m_ovr) begin
                hw(8'h04, 32'h0000_000C, bell);
                hread_chk("R9 W1C overrun and irq", 8'h04);
                chk("R8 irq cleared", 32'(host_irq), 32'h0);
            end
        end

        bread(8'h04, d);
        chk("R1 final status consistent", d, f_status());
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule